// File: doc/BRIEF.md
# Sequential Fetch Address Generator

This block keeps the instruction address of a simple processor that executes only straight-line code. Each rising clock edge loads the address register with one of two values. While reset is high it loads zero. Otherwise it loads the current address plus four.

The adder is not a general two-operand adder. It is a reduced carry chain built for the fixed constant four. The two lowest address bits are real register bits, so traces show the full byte address. They always hold zero.

The next value is picked by a one-hot selector with one slot per source. Targets for branches, jumps or exceptions can be added later as extra slots without changing the register or the incrementer. The block has no data stream: clock and reset are its only inputs, and the address is a plain output with no valid or ready handshake.

Top module: `pc_update_unit`

## Requirements
- R1: At any rising edge where `rst` is high, `pc_addr` becomes zero after that edge, whatever its previous value.
- R2: At a rising edge where `rst` is low, `pc_addr` becomes its previous value plus 4, modulo 2^ADDR_W.
- R3: Bits 1:0 of `pc_addr` read zero after every edge that follows the first reset edge.
- R4: From the highest aligned address (all ones except bits 1:0) an edge without reset gives zero. No overflow is flagged.
- R5: If `rst` stays high for several edges, `pc_addr` stays at zero. The first edge after `rst` is released gives 4.
- R6: If `rst` is raised in the middle of a run of increments, it takes effect at the next edge. Counting then resumes from zero.
- R7: The address width is the parameter ADDR_W (default 32, minimum 3). R2 to R4 hold at any legal width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; selects the zero source |
| pc_addr | output | ADDR_W | Current instruction byte address |

## Verification
Every cycle, embedded properties check four rules: the load to zero after a reset edge, the plus-four step between non-reset edges, the zero low bits, and the wrap from the top aligned address. The incrementer also checks that its own output minus its input is four. What the properties cannot show is the full sequence over time. The bench drives reset held over several cycles, a release, a reset raised in the middle of a run, and several complete wraps of a narrow instance. Each address is compared with an independent model through a scoreboard.

// File: rtl/pc_pkg.sv
package pc_pkg;
  // Slot numbers of the next-address selector. New target sources go
  // above NXT_SEQ; NXT_COUNT grows with them.
  typedef enum int unsigned {
    NXT_ZERO  = 0,
    NXT_SEQ   = 1,
    NXT_COUNT = 2
  } nxt_src_e;

  localparam int unsigned STEP_BYTES = 4;
  localparam int unsigned STEP_LSB   = 2;  // log2 of STEP_BYTES
endpackage

// File: rtl/pc_inc4.sv
// Reduced adder for a constant operand of four: the bits below the step
// pass through, the step bit flips, and a half-adder chain carries upward.
module pc_inc4 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] sum
);
  import pc_pkg::*;

  localparam int unsigned LSB = STEP_LSB;

  logic [W:LSB+1] carry;

  assign sum[LSB-1:0] = a[LSB-1:0];
  assign sum[LSB]     = ~a[LSB];
  assign carry[LSB+1] = a[LSB];

  genvar gi;
  generate
    for (gi = LSB + 1; gi < W; gi++) begin : g_chain
      assign sum[gi]     = a[gi] ^ carry[gi];
      assign carry[gi+1] = a[gi] & carry[gi];
    end
  endgenerate

  // R2
  always_comb begin
    inc_delta_chk: assert (W'(sum - a) == W'(STEP_BYTES));
  end
endmodule

// File: rtl/pc_next_sel.sv
// One-hot AND-OR selector over N_SRC candidate next addresses.
module pc_next_sel #(
  parameter int unsigned W     = 32,
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0][W-1:0] src,
  input  logic [N_SRC-1:0]        sel_oh,
  output logic [W-1:0]            nxt
);
  logic [N_SRC-1:0][W-1:0] gated;

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_gate
      assign gated[gi] = sel_oh[gi] ? src[gi] : '0;
    end
  endgenerate

  always_comb begin
    nxt = '0;
    for (int i = 0; i < N_SRC; i++) begin
      nxt = nxt | gated[i];
    end
  end
endmodule

// File: rtl/pc_update_unit.sv
module pc_update_unit #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] pc_addr
);
  import pc_pkg::*;

  localparam int unsigned NSRC = NXT_COUNT;
  localparam int unsigned ZI   = NXT_ZERO;
  localparam int unsigned SI   = NXT_SEQ;
  localparam logic [ADDR_W-1:0] TOP_ADDR = {{(ADDR_W-STEP_LSB){1'b1}}, {STEP_LSB{1'b0}}};

  logic [ADDR_W-1:0]            addr_q;
  logic [ADDR_W-1:0]            addr_inc;
  logic [ADDR_W-1:0]            addr_nxt;
  logic [NSRC-1:0][ADDR_W-1:0]  cand;
  logic [NSRC-1:0]              pick;

  pc_inc4 #(.W(ADDR_W)) u_inc (
    .a   (addr_q),
    .sum (addr_inc)
  );

  always_comb begin
    cand     = '0;
    cand[ZI] = '0;
    cand[SI] = addr_inc;
    pick     = '0;
    if (rst) pick[ZI] = 1'b1;
    else     pick[SI] = 1'b1;
  end

  pc_next_sel #(.W(ADDR_W), .N_SRC(NSRC)) u_sel (
    .src    (cand),
    .sel_oh (pick),
    .nxt    (addr_nxt)
  );

  always_ff @(posedge clk) begin
    addr_q <= addr_nxt;
  end

  assign pc_addr = addr_q;

  // Checking support: set once a reset edge has been seen.
  logic armed_q = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b1;
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> pc_addr == '0);

  // R2
  step_four_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |=> pc_addr == ADDR_W'($past(pc_addr) + ADDR_W'(STEP_BYTES)));

  // R3
  low_bits_chk: assert property (@(posedge clk) armed_q |-> pc_addr[STEP_LSB-1:0] == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && pc_addr == TOP_ADDR) |=> pc_addr == '0);
endmodule

// File: tb/tb_pc_update_unit.sv
module tb_pc_update_unit;
  localparam int unsigned NW = 8;

  typedef struct {
    logic [31:0]   wide;
    logic [NW-1:0] narrow;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0]   pc_wide;
  logic [NW-1:0] pc_narrow;

  int total = 0;
  int bad   = 0;
  exp_t sb[$];
  logic [31:0]   m_wide   = '0;
  logic [NW-1:0] m_narrow = '0;
  logic          done     = 1'b0;

  always #2.5 clk = ~clk;

  pc_update_unit dut (.clk(clk), .rst(rst), .pc_addr(pc_wide));
  pc_update_unit #(.ADDR_W(NW)) dut_small (.clk(clk), .rst(rst), .pc_addr(pc_narrow));

  // Driver: sets reset for the next edge and pushes the model's result.
  task automatic drive(input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r;
    if (r) begin
      m_wide = '0; m_narrow = '0;
    end else begin
      m_wide = m_wide + 32'd4; m_narrow = m_narrow + NW'(4);
    end
    e.wide = m_wide; e.narrow = m_narrow;
    e.req = (!r && m_narrow == '0) ? "R4" : tag;
    sb.push_back(e);
  endtask

  // Monitor: samples 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (pc_wide !== e.wide) begin
          bad++;
          $display("FAIL %s wide: actual=%h expected=%h", e.req, pc_wide, e.wide);
        end
        total++;
        if (pc_narrow !== e.narrow) begin
          bad++;
          $display("FAIL %s R7 narrow: actual=%h expected=%h", e.req, pc_narrow, e.narrow);
        end
        total++;
        if (pc_wide[1:0] !== 2'b00 || pc_narrow[1:0] !== 2'b00) begin
          bad++;
          $display("FAIL R3 low bits: actual=%b/%b expected=00", pc_wide[1:0], pc_narrow[1:0]);
        end
      end
    end
  end

  initial begin
    fork
      begin
        // R1, R5: reset held over several edges
        for (int i = 0; i < 3; i++) drive(1'b1, "R1");
        // R5: the first edge after release gives 4
        drive(1'b0, "R5");
        // R2: a run of increments
        for (int i = 0; i < 40; i++) drive(1'b0, "R2");
        // R6: reset in the middle of a run, then counting resumes
        drive(1'b1, "R6");
        drive(1'b0, "R6");
        // R4: several wraps of the narrow instance, plus a long wide run
        for (int i = 0; i < 300; i++) drive(1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule